// File: doc/BRIEF.md
# Impulse Response Self-Test Controller

This block is a built-in test engine that sits in front of a fixed-point FIR filter and checks its tap set end to end. When it is started, it sends one nonzero "unity" sample into the filter input, then zero samples only. The transfer uses a valid/ready handshake. Unity is one input LSB shifted left by the number of LSBs that the filter drops from its product. After the shift, each filter output equals the tap value itself.

The controller watches the filter's output sample stream. It discards the first `PIPE_LAT` samples as pipeline delay. It then compares the next `NUM_TAPS` samples, in order, against an expected tap table that is held in registers and loaded through a write port before the run. The window ends with one more sample, which must be zero. This tail check catches an extra tap, a shifted tap or a reversed tap set. The run covers `NUM_TAPS + PIPE_LAT + 1` samples in each direction. At the end the block raises a done flag and a pass flag. On a failure it also reports the tap index of the first disagreeing sample.

Top module: `impulse_selftest`

## Requirements
- R1: While `rst_ni` is low and after it is released, `busy_o`, `done_o`, `pass_o`, `fail_o` and `stim_valid_o` are 0.
- R2: After an accepted start, exactly `NUM_TAPS+PIPE_LAT+1` samples are handed over on the stimulus port. The first has the value `1 << DROP_BITS` (4 by default) and all later ones are 0. `stim_valid_o` then drops.
- R3: While `stim_valid_o` is high and `stim_ready_i` is low, `stim_valid_o` stays high and `stim_data_o` stays unchanged.
- R4: The first `PIPE_LAT` output samples after a start are never compared, whatever their value.
- R5: Output samples `PIPE_LAT+i`, for i from 0 to `NUM_TAPS-1`, are compared with table entry i. Taps that repeat or are zero are each compared in their own position. If every comparison holds, `pass_o` is 1 at done.
- R6: Output sample `PIPE_LAT+NUM_TAPS` must be zero. A nonzero value there fails the run with index `NUM_TAPS`.
- R7: `fail_idx_o` holds the tap index of the first mismatching sample. Later mismatches in the same run do not change it.
- R8: `done_o` rises once `NUM_TAPS+PIPE_LAT+1` output samples have been taken. It holds until the next accepted start, and `busy_o` is then 0. `pass_o` equals `done_o & ~fail_o`.
- R9: A start pulse while `busy_o` is 1 is ignored. A table write while `busy_o` is 1 is ignored.
- R10: An accepted start clears `done_o`, `fail_o` and `fail_idx_o` in the next cycle and raises `busy_o`.
- R11: A table write whose address is `NUM_TAPS` or higher changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Expected-table write strobe |
| tbl_addr_i | input | IDX_W | Table entry (tap index) to write |
| tbl_data_i | input | OUT_W | Expected tap value, output format |
| start_i | input | 1 | Start pulse, honoured when idle |
| stim_valid_o | output | 1 | Stimulus sample valid |
| stim_ready_i | input | 1 | Filter accepts stimulus sample |
| stim_data_o | output | IN_W | Stimulus sample |
| resp_valid_i | input | 1 | Filter output sample valid |
| resp_data_i | input | OUT_W | Filter output sample |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished |
| pass_o | output | 1 | Finished with no mismatch |
| fail_o | output | 1 | A mismatch was seen in this run |
| fail_idx_o | output | IDX_W | Tap index of the first mismatch |

## Verification
Two events can land in the same cycle: the comparison of the last sample in the window and the completion of the run. A run that corrupts only the tail sample therefore has to show `done_o`, `fail_o` and `fail_idx_o = NUM_TAPS` together at its end. The other collision is a start pulse or a table write that arrives while a run is in progress. The bench issues both in the same cycle in the middle of a run. It then judges the result from the stimulus sample count, the verdict of that run and the verdict of a clean follow-up run. The bench also sweeps a single corrupted output sample across every tap position and adds a second, later corruption. For each position it expects exactly that index to be reported.

// File: rtl/ist_pkg.sv
package ist_pkg;
  typedef enum logic {
    STIM_IDLE = 1'b0,
    STIM_SEND = 1'b1
  } stim_st_e;
endpackage

// File: rtl/ist_stim.sv
module ist_stim #(
  parameter int IN_W      = 12,
  parameter int DROP_BITS = 2,
  parameter int TOTAL     = 12,
  parameter int CNT_W     = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [IN_W-1:0] data_o,
  output logic            busy_o
);
  import ist_pkg::*;

  localparam logic [IN_W-1:0] UNIT = IN_W'(1) << DROP_BITS;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

  stim_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= STIM_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        STIM_IDLE: if (start_i) begin
          st_q  <= STIM_SEND;
          cnt_q <= '0;
        end
        STIM_SEND: if (ready_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= STIM_IDLE;
        end
        default: st_q <= STIM_IDLE;
      endcase
    end
  end

  assign valid_o = (st_q == STIM_SEND);
  assign busy_o  = valid_o;
  assign data_o  = (cnt_q == '0) ? UNIT : '0;
endmodule

// File: rtl/ist_table.sv
module ist_table #(
  parameter int NUM_TAPS = 8,
  parameter int D_W      = 16,
  parameter int IDX_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [D_W-1:0]   wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [D_W-1:0]   rdata_o
);
  logic [D_W-1:0] ent [NUM_TAPS];

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_ent
    logic [D_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  val_q <= '0;
      else if (we_i && waddr_i == IDX_W'(g))        val_q <= wdata_i;
    end
    assign ent[g] = val_q;
  end

  // indices past the last tap read as zero: the tail must be silent
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_TAPS; i++)
      if (raddr_i == IDX_W'(i)) rdata_o = ent[i];
  end
endmodule

// File: rtl/ist_check.sv
module ist_check #(
  parameter int NUM_TAPS = 8,
  parameter int PIPE_LAT = 3,
  parameter int D_W      = 16,
  parameter int IDX_W    = 4,
  parameter int TOTAL    = 12,
  parameter int CNT_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             resp_valid_i,
  input  logic [D_W-1:0]   resp_data_i,
  input  logic [D_W-1:0]   exp_data_i,
  output logic [IDX_W-1:0] tap_idx_o,
  output logic             armed_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [IDX_W-1:0] fail_idx_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0] rx_q;
  logic             in_win;
  logic             take;
  logic             miss;

  if (PIPE_LAT == 0) begin : g_nolat
    assign in_win = 1'b1;
  end else begin : g_lat
    assign in_win = (rx_q >= CNT_W'(PIPE_LAT));
  end

  assign tap_idx_o = IDX_W'(rx_q - CNT_W'(PIPE_LAT));
  assign take      = resp_valid_i && armed_o;
  assign miss      = take && in_win && (resp_data_i != exp_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q       <= '0;
      armed_o    <= 1'b0;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
      fail_idx_o <= '0;
    end else if (start_i) begin
      rx_q       <= '0;
      armed_o    <= 1'b1;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
      fail_idx_o <= '0;
    end else if (take) begin
      rx_q <= rx_q + 1'b1;
      if (rx_q == LAST) begin
        armed_o <= 1'b0;
        done_o  <= 1'b1;
      end
      if (miss && !fail_o) begin
        fail_o     <= 1'b1;
        fail_idx_o <= tap_idx_o;
      end
    end
  end
endmodule

// File: rtl/impulse_selftest.sv
module impulse_selftest #(
  parameter int NUM_TAPS  = 8,
  parameter int PIPE_LAT  = 3,
  parameter int DROP_BITS = 2,
  parameter int IN_W      = 12,
  parameter int OUT_W     = 16,
  localparam int IDX_W    = $clog2(NUM_TAPS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tbl_we_i,
  input  logic [IDX_W-1:0] tbl_addr_i,
  input  logic [OUT_W-1:0] tbl_data_i,
  input  logic             start_i,
  output logic             stim_valid_o,
  input  logic             stim_ready_i,
  output logic [IN_W-1:0]  stim_data_o,
  input  logic             resp_valid_i,
  input  logic [OUT_W-1:0] resp_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic [IDX_W-1:0] fail_idx_o
);
  localparam int TOTAL = NUM_TAPS + PIPE_LAT + 1;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic             stim_busy;
  logic             armed;
  logic             start_ok;
  logic             we_ok;
  logic [IDX_W-1:0] tap_idx;
  logic [OUT_W-1:0] exp_data;

  assign busy_o   = stim_busy | armed;
  assign start_ok = start_i && !busy_o;
  assign we_ok    = tbl_we_i && !busy_o;
  assign pass_o   = done_o && !fail_o;

  ist_stim #(
    .IN_W(IN_W), .DROP_BITS(DROP_BITS), .TOTAL(TOTAL), .CNT_W(CNT_W)
  ) u_stim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_ok),
    .ready_i (stim_ready_i),
    .valid_o (stim_valid_o),
    .data_o  (stim_data_o),
    .busy_o  (stim_busy)
  );

  ist_table #(
    .NUM_TAPS(NUM_TAPS), .D_W(OUT_W), .IDX_W(IDX_W)
  ) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_ok),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .raddr_i (tap_idx),
    .rdata_o (exp_data)
  );

  ist_check #(
    .NUM_TAPS(NUM_TAPS), .PIPE_LAT(PIPE_LAT), .D_W(OUT_W),
    .IDX_W(IDX_W), .TOTAL(TOTAL), .CNT_W(CNT_W)
  ) u_check (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_ok),
    .resp_valid_i (resp_valid_i),
    .resp_data_i  (resp_data_i),
    .exp_data_i   (exp_data),
    .tap_idx_o    (tap_idx),
    .armed_o      (armed),
    .done_o       (done_o),
    .fail_o       (fail_o),
    .fail_idx_o   (fail_idx_o)
  );
endmodule

// File: rtl/ist_chk.sv
module ist_chk #(
  parameter int NUM_TAPS  = 8,
  parameter int PIPE_LAT  = 3,
  parameter int DROP_BITS = 2,
  parameter int IN_W      = 12,
  parameter int IDX_W     = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             stim_valid_o,
  input logic             stim_ready_i,
  input logic [IN_W-1:0]  stim_data_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             pass_o,
  input logic             fail_o,
  input logic [IDX_W-1:0] fail_idx_o
);
  localparam int TOTAL = NUM_TAPS + PIPE_LAT + 1;
  localparam logic [IN_W-1:0] UNIT = IN_W'(1) << DROP_BITS;

  int sent_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        sent_q <= 0;
    else if (start_i && !busy_o)        sent_q <= 0;
    else if (stim_valid_o && stim_ready_i) sent_q <= sent_q + 1;
  end

  // R3
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stim_valid_o && !stim_ready_i |=> stim_valid_o && $stable(stim_data_o));
  // R2
  stim_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stim_valid_o && stim_data_o != '0 |-> stim_data_o == UNIT && sent_q == 0);
  // R2
  stim_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stim_valid_o |-> sent_q < TOTAL);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !stim_valid_o);
  // R8
  pass_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o && !fail_o);
  // R7
  first_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && $past(fail_o) |-> $stable(fail_idx_o));
  // R6
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> fail_idx_o <= IDX_W'(NUM_TAPS));
  // R10
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !done_o && !fail_o && fail_idx_o == '0);
endmodule

bind impulse_selftest ist_chk #(
  .NUM_TAPS(NUM_TAPS), .PIPE_LAT(PIPE_LAT), .DROP_BITS(DROP_BITS),
  .IN_W(IN_W), .IDX_W($clog2(NUM_TAPS + 1))
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .stim_valid_o (stim_valid_o),
  .stim_ready_i (stim_ready_i),
  .stim_data_o  (stim_data_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .pass_o       (pass_o),
  .fail_o       (fail_o),
  .fail_idx_o   (fail_idx_o)
);

// File: tb/impulse_selftest_tb.sv
`timescale 1ns/1ps
module impulse_selftest_tb;
  localparam int N     = 8;
  localparam int P     = 3;
  localparam int K     = 2;
  localparam int IN_W  = 12;
  localparam int OUT_W = 16;
  localparam int IDX_W = 4;
  localparam int TOTAL = N + P + 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             tbl_we_i = 1'b0;
  logic [IDX_W-1:0] tbl_addr_i = '0;
  logic [OUT_W-1:0] tbl_data_i = '0;
  logic             start_i = 1'b0;
  logic             stim_valid_o;
  logic             stim_ready_i = 1'b0;
  logic [IN_W-1:0]  stim_data_o;
  logic             resp_valid_i = 1'b0;
  logic [OUT_W-1:0] resp_data_i = '0;
  logic             busy_o, done_o, pass_o, fail_o;
  logic [IDX_W-1:0] fail_idx_o;

  impulse_selftest #(
    .NUM_TAPS(N), .PIPE_LAT(P), .DROP_BITS(K), .IN_W(IN_W), .OUT_W(OUT_W)
  ) u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int n_vec = 0, n_bad = 0, cyc = 0;
  int tap_tbl [N];
  int coef_f  [N];
  int xh      [N];
  int acc_vals[$];
  int dq[$];
  int outq[$];
  int out_cnt = 0;
  int fault_at = -1, fault_at2 = -1;
  int rdy_mode = 0, gap_mode = 0;
  logic            prev_v = 1'b0, prev_r = 1'b0;
  logic [IN_W-1:0] prev_d = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // filter model: products of x and coef, k LSBs dropped, P junk samples first
  always @(negedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
    if (rst_ni) begin
      if (prev_v && !prev_r)  // R3 hold across a stall
        check(stim_valid_o && stim_data_o == prev_d, "R3", int'(stim_data_o), int'(prev_d));
      case (rdy_mode)
        1:       stim_ready_i = (cyc % 2) == 0;
        2:       stim_ready_i = (cyc % 3) != 0;
        default: stim_ready_i = 1'b1;
      endcase
      prev_v = stim_valid_o; prev_r = stim_ready_i; prev_d = stim_data_o;
      if (stim_valid_o && stim_ready_i) begin
        int y;
        acc_vals.push_back(int'($signed(stim_data_o)));
        for (int i = N - 1; i > 0; i--) xh[i] = xh[i-1];
        xh[0] = int'($signed(stim_data_o));
        y = 0;
        for (int i = 0; i < N; i++) y += coef_f[i] * xh[i];
        y = y >>> K;
        dq.push_back(y);
        outq.push_back(dq.pop_front());
      end
      if (outq.size() > 0 && (gap_mode == 0 || (cyc % 3) != 1)) begin
        int v;
        v = outq.pop_front();
        if (out_cnt == fault_at || out_cnt == fault_at2) v += 5;
        out_cnt++;
        resp_valid_i = 1'b1;
        resp_data_i  = v[OUT_W-1:0];
      end else begin
        resp_valid_i = 1'b0;
      end
    end
  end

  task automatic write_tbl(input int a, input int v);
    @(negedge clk_i);
    tbl_we_i = 1'b1; tbl_addr_i = a[IDX_W-1:0]; tbl_data_i = v[OUT_W-1:0];
    @(negedge clk_i);
    tbl_we_i = 1'b0;
  endtask

  task automatic load_tbl();
    for (int i = 0; i < N; i++) write_tbl(i, tap_tbl[i]);
  endtask

  task automatic run_case(input string req, input bit exp_pass, input int exp_idx, input bit poke);
    int t;
    @(negedge clk_i);
    acc_vals.delete(); dq.delete(); outq.delete(); out_cnt = 0;
    for (int i = 0; i < N; i++) xh[i] = 0;
    for (int j = 0; j < P; j++) dq.push_back(100 + 7 * j);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R10 start clears status, run begins
    check(busy_o && !done_o && !fail_o && fail_idx_o == '0, "R10", {busy_o, done_o, fail_o}, 4);
    if (poke) begin
      repeat (4) @(negedge clk_i);
      // R9 second start and a table write in the same cycle, mid-run
      start_i = 1'b1; tbl_we_i = 1'b1; tbl_addr_i = '0; tbl_data_i = 16'd999;
      @(negedge clk_i);
      start_i = 1'b0; tbl_we_i = 1'b0;
    end
    t = 0;
    while (!done_o && t < 2000) begin @(negedge clk_i); t++; end
    check(done_o && !busy_o, "R8", {done_o, busy_o}, 2);
    check(pass_o == exp_pass && fail_o == !exp_pass, req, int'(pass_o), int'(exp_pass));
    if (!exp_pass) check(fail_idx_o == IDX_W'(exp_idx), req, int'(fail_idx_o), exp_idx);
    check(acc_vals.size() == TOTAL, "R2", acc_vals.size(), TOTAL);
    for (int i = 0; i < acc_vals.size(); i++)
      check(acc_vals[i] == ((i == 0) ? (1 << K) : 0), "R2", acc_vals[i], (i == 0) ? (1 << K) : 0);
    repeat (3) @(negedge clk_i);
    check(done_o && pass_o == exp_pass, "R8", int'(done_o), 1);
  endtask

  initial begin
    int first;
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !pass_o && !fail_o && !stim_valid_o, "R1",
          {busy_o, done_o, pass_o, fail_o, stim_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o && !pass_o && !fail_o && !stim_valid_o, "R1",
          {busy_o, done_o, pass_o, fail_o, stim_valid_o}, 0);

    tap_tbl = '{5, -9, 14, 31, 22, -4, 0, 2};
    coef_f  = tap_tbl;
    load_tbl();
    run_case("R5", 1'b1, 0, 1'b0);
    rdy_mode = 1; gap_mode = 1;
    run_case("R5", 1'b1, 0, 1'b0);            // R3 stalls exercised

    rdy_mode = 2;
    tap_tbl = '{-3, 0, 19, 32, 19, 0, -3, 0}; // repeated and zero taps
    coef_f  = tap_tbl;
    load_tbl();
    run_case("R5", 1'b1, 0, 1'b0);

    tap_tbl = '{5, -9, 14, 31, 22, -4, 0, 2};
    load_tbl();
    for (int i = 0; i < N; i++) coef_f[i] = tap_tbl[N-1-i];
    first = N;
    for (int i = N - 1; i >= 0; i--) if (coef_f[i] != tap_tbl[i]) first = i;
    run_case("R5", 1'b0, first, 1'b0);        // reversed taps
    coef_f = tap_tbl;

    fault_at = 0; fault_at2 = P - 1;
    run_case("R4", 1'b1, 0, 1'b0);            // latency samples ignored

    for (int i = 0; i < N; i++) begin
      fault_at = P + i; fault_at2 = P + N - 1;
      rdy_mode = i % 3; gap_mode = i % 2;
      run_case("R7", 1'b0, i, 1'b0);          // later mismatch must not overwrite
    end
    fault_at = P + N; fault_at2 = -1;
    run_case("R6", 1'b0, N, 1'b0);            // tail nonzero, same cycle as done
    fault_at = -1;
    run_case("R10", 1'b1, 0, 1'b0);

    run_case("R9", 1'b1, 0, 1'b1);
    run_case("R9", 1'b1, 0, 1'b0);            // entry 0 must still hold its old value

    write_tbl(N, 777);
    write_tbl(15, -1);
    run_case("R11", 1'b1, 0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule